// File: doc/BRIEF.md
# Serial CRC7 Frame Checker

This block computes and checks the 7-bit cyclic redundancy code carried by command-line frames, one bit per accepted cycle. A frame begins with a clear pulse. The clear also captures the frame length (48 or 136 bits) and the direction (transmit or receive). Each cycle with the bit-valid input high then moves an internal bit position forward by one. From that position the block knows which bits feed the checksum, which form the CRC field and which one is the end bit. Line driving is left to the surrounding logic.

In a short frame, all 40 bits ahead of the CRC field feed the checksum, start and transmission bits included. In a long frame, the first eight bits are skipped (start bit, transmission bit and six reserved bits), and the next 120 bits feed the checksum. In transmit, the block shows the finished remainder on a serial output during the seven CRC slots, most significant bit first. In receive, it compares each incoming CRC bit with the computed remainder and raises a match flag after the end bit.

Top module: `crc7_frame_unit`

## Requirements
- R1: After reset or a clear pulse, `crc_val` is 0, `crc_ok` is 0 and `crc_out` is 0.
- R2: In a short frame (`long_frm` low at clear), `crc_val` equals the remainder of M(x)·x^7 divided by x^7+x^3+1 once the first 40 accepted bits have been taken in. M(x) takes the first accepted bit as its highest-order term.
- R3: In a long frame (`long_frm` high at clear), the first 8 accepted bits have no effect on `crc_val`, and the checksum covers accepted bits 8 to 127.
- R4: In the CRC field (7 bits), at the end bit and afterwards, `crc_val` holds the remainder unchanged until the next clear.
- R5: In transmit (`tx_mode` high at clear), during the k-th CRC slot (k = 0..6) `crc_out` equals bit 6−k of `crc_val`. So the remainder is sent MSB first, and `crc_out` is 0 in every other slot.
- R6: In receive, `crc_ok` goes to 1 on the cycle after the end bit is accepted, provided all 7 received CRC bits equal the computed remainder.
- R7: In receive, if any one of the 7 received CRC bits differs from the remainder, `crc_ok` stays 0.
- R8: A cycle with `bit_vld` low and `clr` low leaves `crc_val`, `crc_ok` and the bit position unchanged, whatever `bit_in` is.
- R9: Frame length and direction are taken only at clear. In transmit, `crc_ok` stays 0.
- R10: Bits accepted after the end bit change neither `crc_val` nor `crc_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start of frame; captures `long_frm` and `tx_mode` |
| bit_vld | input | 1 | Accept `bit_in` this cycle |
| bit_in | input | 1 | Serial frame bit, first bit of the frame first |
| long_frm | input | 1 | 1 = 136-bit frame, 0 = 48-bit frame |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| crc_val | output | 7 | Current checksum register |
| crc_out | output | 1 | Serial CRC bit during the CRC slots in transmit |
| crc_ok | output | 1 | Received CRC matched the computed remainder |

## Verification
Short command frames with a known index and argument pin the polynomial and the bit order against a fixed expected code. Random short and long frames then exercise the full covered range. Two long frames that share their content but differ in the header show whether the eight skipped bits leak into the checksum. Frames with one flipped CRC bit separate a full-field compare from a partial one. Transmit frames show whether the serial output order is MSB first. Idle gaps with toggling data, and extra bits after the end bit, check that stray input is ignored.

// File: rtl/crc7_pkg.sv
package crc7_pkg;
    localparam int CRC_W = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [2:0] {
        PH_SKIP,
        PH_COVER,
        PH_CRC,
        PH_END,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/crc7_phase_ctr.sv
module crc7_phase_ctr
    import crc7_pkg::*;
#(
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136,
    parameter int LONG_SKIP = 8,
    parameter int IW        = $clog2(CRC_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          bit_vld,
    input  logic          long_frm,
    output phase_t        phase,
    output logic [IW-1:0] crc_idx
);
    localparam int PW = $clog2(LONG_LEN + 1);
    localparam logic [PW-1:0] S_LEN  = PW'(SHORT_LEN);
    localparam logic [PW-1:0] L_LEN  = PW'(LONG_LEN);
    localparam logic [PW-1:0] S_FLD  = PW'(SHORT_LEN - CRC_W - 1);
    localparam logic [PW-1:0] L_FLD  = PW'(LONG_LEN - CRC_W - 1);
    localparam logic [PW-1:0] L_SKIP = PW'(LONG_SKIP);

    logic          long_q;
    logic [PW-1:0] pos;
    logic [PW-1:0] len_w;
    logic [PW-1:0] fld_w;
    logic [PW-1:0] skip_w;

    always_comb begin
        len_w  = long_q ? L_LEN  : S_LEN;
        fld_w  = long_q ? L_FLD  : S_FLD;
        skip_w = long_q ? L_SKIP : '0;
        if (pos >= len_w)
            phase = PH_DONE;
        else if (pos == len_w - 1'b1)
            phase = PH_END;
        else if (pos >= fld_w)
            phase = PH_CRC;
        else if (pos < skip_w)
            phase = PH_SKIP;
        else
            phase = PH_COVER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            long_q  <= 1'b0;
            pos     <= '0;
            crc_idx <= '0;
        end else if (clr) begin
            long_q  <= long_frm;
            pos     <= '0;
            crc_idx <= '0;
        end else if (bit_vld && phase != PH_DONE) begin
            pos <= pos + 1'b1;
            if (phase == PH_CRC)
                crc_idx <= crc_idx + 1'b1;
        end
    end
endmodule

// File: rtl/crc7_lfsr.sv
module crc7_lfsr
    import crc7_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift_en,
    input  logic bit_in,
    output crc_t crc_q
);
    logic fb;
    crc_t nxt;

    assign fb = bit_in ^ crc_q[CRC_W-1];

    generate
        for (genvar g = 0; g < CRC_W; g++) begin : g_tap
            if (g == 0) begin : g_in
                assign nxt[g] = fb;
            end else if (CRC_POLY[g]) begin : g_xor
                assign nxt[g] = crc_q[g-1] ^ fb;
            end else begin : g_pass
                assign nxt[g] = crc_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (shift_en)
            crc_q <= nxt;
    end
endmodule

// File: rtl/crc7_cmp.sv
module crc7_cmp (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic chk_en,
    input  logic end_en,
    input  logic tx_q,
    input  logic bit_in,
    input  logic exp_bit,
    output logic crc_ok
);
    logic mism;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mism   <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            if (chk_en && (bit_in != exp_bit))
                mism <= 1'b1;
            if (end_en)
                crc_ok <= !tx_q && !mism;
        end
    end
endmodule

// File: rtl/crc7_frame_unit.sv
module crc7_frame_unit
    import crc7_pkg::*;
#(
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136,
    parameter int LONG_SKIP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             long_frm,
    input  logic             tx_mode,
    output logic [CRC_W-1:0] crc_val,
    output logic             crc_out,
    output logic             crc_ok
);
    localparam int IW = $clog2(CRC_W);

    phase_t        phase;
    logic [IW-1:0] crc_idx;
    logic [IW-1:0] sel;
    logic          tx_q;
    crc_t          crc_q;
    logic          exp_bit;

    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= 1'b0;
        else if (clr)
            tx_q <= tx_mode;
    end

    crc7_phase_ctr #(
        .SHORT_LEN(SHORT_LEN),
        .LONG_LEN (LONG_LEN),
        .LONG_SKIP(LONG_SKIP),
        .IW       (IW)
    ) u_pos (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .bit_vld (bit_vld),
        .long_frm(long_frm),
        .phase   (phase),
        .crc_idx (crc_idx)
    );

    crc7_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .shift_en(bit_vld && phase == PH_COVER),
        .bit_in  (bit_in),
        .crc_q   (crc_q)
    );

    assign sel     = IW'(CRC_W - 1) - crc_idx;
    assign exp_bit = crc_q[sel];

    crc7_cmp u_cmp (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .chk_en (bit_vld && phase == PH_CRC),
        .end_en (bit_vld && phase == PH_END),
        .tx_q   (tx_q),
        .bit_in (bit_in),
        .exp_bit(exp_bit),
        .crc_ok (crc_ok)
    );

    assign crc_val = crc_q;
    assign crc_out = tx_q && (phase == PH_CRC) && exp_bit;
endmodule

// File: rtl/crc7_frame_unit_chk.sv
module crc7_frame_unit_chk
    import crc7_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             bit_vld,
    input logic [CRC_W-1:0] crc_val,
    input logic             crc_out,
    input logic             crc_ok,
    input logic             tx_q,
    input phase_t           phase
);
    // R1
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_val == '0 && !crc_ok && !crc_out));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !clr) |=> ($stable(crc_val) && $stable(crc_ok)));

    // R4
    field_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_CRC || phase == PH_END) && !clr) |=> $stable(crc_val));

    // R10
    after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && !clr) |=> ($stable(crc_val) && $stable(crc_ok)));

    // R6
    ok_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_ok) |-> ($past(phase) == PH_END && $past(bit_vld)));

    // R9
    tx_no_ok_chk: assert property (@(posedge clk) disable iff (rst)
        tx_q |-> !crc_ok);

    // R5
    out_slot_chk: assert property (@(posedge clk) disable iff (rst)
        crc_out |-> (tx_q && phase == PH_CRC));
endmodule

bind crc7_frame_unit crc7_frame_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .bit_vld(bit_vld),
    .crc_val(crc_val),
    .crc_out(crc_out),
    .crc_ok (crc_ok),
    .tx_q   (tx_q),
    .phase  (phase)
);

// File: tb/crc7_frame_unit_test.sv
module crc7_frame_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       long_frm = 1'b0;
    logic       tx_mode = 1'b0;
    logic [6:0] crc_val;
    logic       crc_out;
    logic       crc_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crc7_frame_unit uut (
        .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
        .long_frm(long_frm), .tx_mode(tx_mode),
        .crc_val(crc_val), .crc_out(crc_out), .crc_ok(crc_ok)
    );

    function automatic logic [6:0] ref_crc(input logic [135:0] f, input int hi, input int n);
        logic [6:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic fb = f[hi-i] ^ r[6];
            r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] f = '0;
        f[47:0] = {1'b0, 1'b1, idx, arg, 7'h00, 1'b1};
        f[7:1]  = ref_crc(f, 47, 40);
        return f;
    endfunction

    function automatic logic [135:0] mk_long(input logic [7:0] hdr, input logic [119:0] body);
        logic [135:0] f = {hdr, body, 7'h00, 1'b1};
        f[7:1] = ref_crc(f, 127, 120);
        return f;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one frame; checks crc_val, crc_out and crc_ok along the way.
    task automatic send_frame(input logic [135:0] f, input bit lng, input bit tx,
                              input bit gaps, input logic [6:0] exp_crc, input bit exp_ok);
        int len = lng ? 136 : 48;
        int fld = len - 8;
        @(negedge clk);
        clr = 1'b1; long_frm = lng; tx_mode = tx; bit_vld = 1'b0;
        @(negedge clk);
        clr = 1'b0; long_frm = $urandom; tx_mode = $urandom;
        for (int p = 0; p < len; p++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                logic [6:0] held = crc_val;
                bit_vld = 1'b0; bit_in = $urandom;
                @(negedge clk);
                chk(crc_val == held, "R8 idle cycle", crc_val, held);
            end
            if (p == fld)
                chk(crc_val == exp_crc, lng ? "R3 long crc" : "R2 short crc", crc_val, exp_crc);
            if (p >= fld && p < fld + 7)
                chk(crc_out == (tx ? exp_crc[6-(p-fld)] : 1'b0), "R5 serial crc bit",
                    crc_out, tx ? exp_crc[6-(p-fld)] : 1'b0);
            else if (p == 0 || p == len - 1)
                chk(crc_out == 1'b0, "R5 crc_out outside field", crc_out, 0);
            bit_vld = 1'b1; bit_in = f[len-1-p];
            @(negedge clk);
        end
        bit_vld = 1'b0;
        chk(crc_val == exp_crc, "R4 crc held after end", crc_val, exp_crc);
        chk(crc_ok == exp_ok, tx ? "R9 no match in tx" : (exp_ok ? "R6 match" : "R7 mismatch"),
            crc_ok, exp_ok);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [135:0] f;
        logic [6:0]   c;
        logic [119:0] body;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(crc_val == 7'h00, "R1 reset crc_val", crc_val, 0);
        chk(crc_ok == 1'b0, "R1 reset crc_ok", crc_ok, 0);
        chk(crc_out == 1'b0, "R1 reset crc_out", crc_out, 0);

        // Known codes: index 0 arg 0 -> 0x4A, index 17 arg 0 -> 0x2A
        chk(ref_crc(mk_short(6'd0, 32'h0), 47, 40) == 7'h4A, "R2 reference code idx0",
            ref_crc(mk_short(6'd0, 32'h0), 47, 40), 7'h4A);
        send_frame(mk_short(6'd0, 32'h0), 1'b0, 1'b0, 1'b0, 7'h4A, 1'b1);
        send_frame(mk_short(6'd17, 32'h0), 1'b0, 1'b0, 1'b0, 7'h2A, 1'b1);

        // Clear after a frame restores the reset state
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(crc_val == 7'h00 && crc_ok == 1'b0, "R1 clear", {crc_ok, crc_val}, 0);

        // Random short frames, receive, with idle gaps
        for (int k = 0; k < 20; k++) begin
            f = mk_short(6'($urandom), $urandom);
            send_frame(f, 1'b0, 1'b0, 1'b1, f[7:1], 1'b1);
        end

        // Random long frames, including header independence
        for (int k = 0; k < 10; k++) begin
            body = {$urandom, $urandom, $urandom, 24'($urandom)};
            f = mk_long(8'h7F, body);
            send_frame(f, 1'b1, 1'b0, 1'b1, f[7:1], 1'b1);
            c = f[7:1];
            f[135:128] = 8'($urandom);
            send_frame(f, 1'b1, 1'b0, 1'b0, c, 1'b1);
        end

        // One corrupted CRC bit, every position
        for (int b = 1; b <= 7; b++) begin
            f = mk_short(6'($urandom), $urandom);
            c = f[7:1];
            f[b] = ~f[b];
            send_frame(f, 1'b0, 1'b0, 1'b0, c, 1'b0);
        end
        body = {$urandom, $urandom, $urandom, 24'($urandom)};
        f = mk_long(8'h7F, body);
        c = f[7:1];
        f[7] = ~f[7];
        send_frame(f, 1'b1, 1'b0, 1'b1, c, 1'b0);

        // Transmit frames: serial order and no match flag
        for (int k = 0; k < 6; k++) begin
            if (k % 2 == 0) begin
                f = mk_short(6'($urandom), $urandom);
                send_frame(f, 1'b0, 1'b1, 1'b1, f[7:1], 1'b0);
            end else begin
                body = {$urandom, $urandom, $urandom, 24'($urandom)};
                f = mk_long(8'h7F, body);
                send_frame(f, 1'b1, 1'b1, 1'b0, f[7:1], 1'b0);
            end
        end

        // Extra bits after the end bit are ignored
        f = mk_short(6'd5, 32'hDEADBEEF);
        send_frame(f, 1'b0, 1'b0, 1'b0, f[7:1], 1'b1);
        for (int k = 0; k < 6; k++) begin
            bit_vld = 1'b1; bit_in = $urandom;
            @(negedge clk);
        end
        bit_vld = 1'b0;
        chk(crc_val == f[7:1], "R10 crc_val after extra bits", crc_val, f[7:1]);
        chk(crc_ok == 1'b1, "R10 crc_ok after extra bits", crc_ok, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule